// File: doc/BRIEF.md
# DSD Bitstream Receiver with Selectable Clock Ratio

This block takes a stereo one-bit Direct Stream Digital audio stream that runs synchronously to the master clock. It produces a sampling strobe by dividing the master clock by a ratio. A 3-bit code selects the ratio from a fixed table. Codes with the top bit clear select 64x oversampled streams, and codes with the top bit set select 128x streams. On each strobe the block samples the left and right data lines and shifts the two bits into 8-bit words. After every eighth strobe it raises a one-cycle word-valid pulse.

The code is interpreted as a clock ratio only while the functional-mode input selects DSD. In the other mode, the same code belongs to the PCM path and this receiver stays idle. Only two codes are usable at all times. The other six extended codes work only while the unlock flag is set. Power-down stops the divider and discards any partly collected word.

Top module: `dsd_rate_rx`

## Requirements
- R1: With `fmt_code` 000, 001, 010 and 011 (64x stream), `bit_strobe` repeats every 4, 6, 8 and 12 master-clock cycles respectively.
- R2: With `fmt_code` 100, 101, 110 and 111 (128x stream), `bit_strobe` repeats every 2, 3, 4 and 6 master-clock cycles respectively.
- R3: Codes 000 and 100 work regardless of `unlocked`. The six other codes produce no strobe and no word while `unlocked` is 0.
- R4: While `dsd_mode` is 0, no strobe and no word-valid pulse is produced.
- R5: When the receiver becomes active with a code that was already present in the previous cycle, the first strobe comes in the ratio-th active cycle. After that, exactly one strobe comes every ratio cycles.
- R6: In any cycle where `fmt_code` differs from its value in the previous cycle, there is no strobe. The divider and the partial words restart, so the next strobe comes ratio cycles after that cycle, and a word needs eight fresh strobes.
- R7: `dsd_left` and `dsd_right` are sampled in the cycle where `bit_strobe` is 1. The first bit sampled for a word lands in bit 7 and the eighth in bit 0.
- R8: `word_valid` is a one-cycle pulse in the cycle after every eighth strobe. `left_word` and `right_word` take their new values in that same cycle and hold them until the next pulse.
- R9: While `pwr_dn` is 1, there are no strobes and no pulses. The divider and partial words are cleared, so a word completed after power-down holds only bits sampled after it.
- R10: After reset, `bit_strobe`, `word_valid`, `left_word` and `right_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsd_mode | input | 1 | 1 selects DSD interpretation of the format code |
| unlocked | input | 1 | 1 enables the six extended codes |
| pwr_dn | input | 1 | 1 halts and clears the receiver |
| fmt_code | input | 3 | Oversampling/clock-ratio code |
| dsd_left | input | 1 | Left channel bitstream |
| dsd_right | input | 1 | Right channel bitstream |
| bit_strobe | output | 1 | High in the cycle the data lines are sampled |
| word_valid | output | 1 | One-cycle pulse when a new word pair is ready |
| left_word | output | 8 | Last completed left word, first bit in MSB |
| right_word | output | 8 | Last completed right word, first bit in MSB |

## Verification
A change of the ratio code can land in exactly the cycle in which the divider would otherwise fire a strobe. The bench provokes this by running code 100 at ratio 2 and switching to code 000 in the cycle of the second expected strobe. It then expects no strobe in that cycle and the next strobe four cycles later. It also expects no word-valid pulse after seven further strobes, and a pulse after the eighth. Any strobe or pulse that leaks through from the old phase, or from the bit collected before the change, is reported.

// File: rtl/dsd_rate_rx.sv
module dsd_rate_rx #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsd_mode,
  input  logic              unlocked,
  input  logic              pwr_dn,
  input  logic [2:0]        fmt_code,
  input  logic              dsd_left,
  input  logic              dsd_right,
  output logic              bit_strobe,
  output logic              word_valid,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word
);
  localparam int BC_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  ratio_m1;
  logic [CNT_W-1:0]  cnt;
  logic [BC_W-1:0]   bc;
  logic [WORD_W-1:0] lsh, rsh;
  logic [2:0]        fmt_q;
  logic              base_code, active, code_chg, restart, last_bit;

  // ratio minus one per code: 64x {4,6,8,12}, 128x {2,3,4,6}
  always_comb begin
    case (fmt_code)
      3'd0:    ratio_m1 = CNT_W'(3);
      3'd1:    ratio_m1 = CNT_W'(5);
      3'd2:    ratio_m1 = CNT_W'(7);
      3'd3:    ratio_m1 = CNT_W'(11);
      3'd4:    ratio_m1 = CNT_W'(1);
      3'd5:    ratio_m1 = CNT_W'(2);
      3'd6:    ratio_m1 = CNT_W'(3);
      default: ratio_m1 = CNT_W'(5);
    endcase
  end

  assign base_code  = (fmt_code[1:0] == 2'b00);
  assign active     = dsd_mode && !pwr_dn && (base_code || unlocked);
  assign code_chg   = (fmt_code != fmt_q);
  assign restart    = !active || code_chg;
  assign bit_strobe = !restart && (cnt == ratio_m1);
  assign last_bit   = (bc == BC_W'(WORD_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q      <= '0;
      cnt        <= '0;
      bc         <= '0;
      lsh        <= '0;
      rsh        <= '0;
      word_valid <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
    end else begin
      fmt_q      <= fmt_code;
      word_valid <= 1'b0;
      if (restart) begin
        cnt <= '0;
        bc  <= '0;
        lsh <= '0;
        rsh <= '0;
      end else if (bit_strobe) begin
        cnt <= '0;
        lsh <= {lsh[WORD_W-2:0], dsd_left};
        rsh <= {rsh[WORD_W-2:0], dsd_right};
        if (last_bit) begin
          bc         <= '0;
          left_word  <= {lsh[WORD_W-2:0], dsd_left};
          right_word <= {rsh[WORD_W-2:0], dsd_right};
          word_valid <= 1'b1;
        end else begin
          bc <= bc + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_strobe));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r3_locked_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && fmt_code[1:0] != 2'b00) |-> !bit_strobe);
  a_r4_pcm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dsd_mode |=> !word_valid);
  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!word_valid && !bit_strobe || !$past(pwr_dn) || pwr_dn || !bit_strobe));
  a_r9_pd_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !word_valid);
  a_r6_change_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code != $past(fmt_code)) |-> !bit_strobe);
endmodule

// File: tb/dsd_rate_rx_tb_top.sv
`timescale 1ns/1ps
module dsd_rate_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dsd_mode = 1'b0, unlocked = 1'b0, pwr_dn = 1'b1;
  logic [2:0] fmt_code = 3'd0;
  logic       dsd_left = 1'b0, dsd_right = 1'b0;
  logic       bit_strobe, word_valid;
  logic [7:0] left_word, right_word;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dsd_rate_rx dut_i (
    .clk(clk), .rst_n(rst_n), .dsd_mode(dsd_mode), .unlocked(unlocked),
    .pwr_dn(pwr_dn), .fmt_code(fmt_code), .dsd_left(dsd_left), .dsd_right(dsd_right),
    .bit_strobe(bit_strobe), .word_valid(word_valid),
    .left_word(left_word), .right_word(right_word));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic int ratio_of(input int c);
    int r;
    r = ((c & 1) != 0) ? 6 : 4;
    if ((c & 2) != 0) r = r * 2;
    if (c >= 4) r = r / 2;
    return r;
  endfunction

  task automatic setup(input int c, input bit unl, input bit mode);
    @(negedge clk);
    pwr_dn = 1'b1; fmt_code = 3'(c); unlocked = unl; dsd_mode = mode;
    dsd_left = 1'b0; dsd_right = 1'b0;
    @(negedge clk);
    #1 chk(!bit_strobe && !word_valid, "R9", int'(bit_strobe), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!bit_strobe && !word_valid, "R10", int'(word_valid), 0);
    chk(left_word == 0 && right_word == 0, "R10", int'(left_word), 0);
    rst_n = 1'b1;

    // sweep every code with and without unlock
    for (int c = 0; c < 8; c++) begin
      for (int u = 0; u < 2; u++) begin
        int r; bit en; logic [7:0] lp, rp; string tag;
        r  = ratio_of(c);
        en = ((c % 4) == 0) || (u == 1);
        lp = 8'h5A ^ 8'(c * 37 + u * 11);
        rp = ~lp ^ 8'(c * 5);
        tag = !en ? "R3" : (c < 4 ? "R1" : "R2");
        setup(c, u[0], 1'b1);
        for (int i = 0; i < 9 * r; i++) begin
          int s; bit es, ev;
          @(negedge clk);
          pwr_dn = 1'b0;
          s = i / r;
          dsd_left  = (s < 8) ? lp[7 - s] : 1'b0;
          dsd_right = (s < 8) ? rp[7 - s] : 1'b0;
          #1;
          es = en && (((i + 1) % r) == 0);
          ev = en && (i == 8 * r);
          chk(bit_strobe == es, tag, int'(bit_strobe), int'(es));
          if (i < r) chk(bit_strobe == es, "R5", int'(bit_strobe), int'(es));
          chk(word_valid == ev, "R8", int'(word_valid), int'(ev));
          if (ev) begin
            chk(left_word == lp, "R7", int'(left_word), int'(lp));
            chk(right_word == rp, "R7", int'(right_word), int'(rp));
          end
        end
      end
    end

    // PCM mode: receiver idle
    setup(4, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); pwr_dn = 1'b0; dsd_left = 1'b1; #1;
      chk(!bit_strobe && !word_valid, "R4", int'(bit_strobe | word_valid), 0);
    end

    // code change colliding with a due strobe
    setup(4, 1'b0, 1'b1);
    for (int i = 0; i < 44; i++) begin
      bit es, ev;
      @(negedge clk);
      pwr_dn = 1'b0; dsd_left = 1'b1; dsd_right = 1'b0;
      if (i == 3) fmt_code = 3'd0;
      #1;
      es = (i == 1) || (i > 3 && ((i - 3) % 4) == 0);
      ev = (i == 36);
      chk(bit_strobe == es, "R6", int'(bit_strobe), int'(es));
      chk(word_valid == ev, "R6", int'(word_valid), int'(ev));
      if (ev) chk(left_word == 8'hFF && right_word == 8'h00, "R6", int'(left_word), 255);
    end

    // power-down in the middle of a word
    setup(0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); pwr_dn = 1'b0; dsd_left = 1'b1; dsd_right = 1'b1; #1;
    end
    @(negedge clk); pwr_dn = 1'b1; #1;
    chk(!bit_strobe, "R9", int'(bit_strobe), 0);
    for (int i = 0; i < 36; i++) begin
      bit ev;
      @(negedge clk); pwr_dn = 1'b0; dsd_left = 1'b0; dsd_right = 1'b1; #1;
      ev = (i == 32);
      chk(word_valid == ev, "R9", int'(word_valid), int'(ev));
      if (ev) begin
        chk(left_word == 8'h00, "R9", int'(left_word), 0);
        chk(right_word == 8'hFF, "R9", int'(right_word), 255);
      end
    end
    @(negedge clk); #1;
    chk(left_word == 8'h00 && right_word == 8'hFF, "R8", int'(right_word), 255);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule